// File: doc/BRIEF.md
# Multiblock CRC-12 Parity Generator

This block computes a 12-bit cyclic redundancy parity word over the scrambled payload of one multiblock. A multiblock is 32 blocks of 64 payload bits, 2048 bits in all. The two sync header bits of each block are left out. One 64-bit payload word enters per clock, qualified by a valid strobe. A start marker flags the first block of each multiblock.

The parity register is cleared before the first bit of every multiblock. It advances by a whole word per clock, using a parallel form of the generator x^12 + x^9 + x^8 + x^3 + x^2 + x + 1. When the 32nd block has been taken in, the finished parity is registered and a one-cycle done pulse is raised. The word then holds, so the header stream of the following multiblock can carry it.

A start marker that arrives partway through a multiblock throws away the partial result and begins again from zero.

Top module: `mbcrc_gen`

## Requirements
- R1: While reset is held and on the first cycle after reset, par_word is 0 and par_done is 0.
- R2: The parity of a multiblock equals the remainder of its 2048 payload bits, multiplied by x^12, divided by x^12+x^9+x^8+x^3+x^2+x+1. The register starts from all zeros for every multiblock.
- R3: par_done is high for exactly one cycle: the cycle after the clock edge that takes in the 32nd valid block of a multiblock.
- R4: par_word changes only on a cycle in which par_done is high, and holds its value otherwise.
- R5: A cycle with blk_valid low leaves the computation untouched. Gaps of any length may appear between blocks of a multiblock.
- R6: A valid block with blk_sop high always starts a new multiblock, with that block as block 1. Any partial result is discarded, even in the middle of a multiblock.
- R7: A valid block with blk_sop low is ignored when no multiblock is open. That is the state after reset, and after the 32nd block until the next start marker.
- R8: blk_sop has no effect in a cycle where blk_valid is low.
- R9: Bit 63 of each payload word enters the division first and bit 0 last. Blocks enter in the order they are presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| blk_valid | input | 1 | A payload word is present on blk_data |
| blk_sop | input | 1 | With blk_valid: this block is the first of a multiblock |
| blk_data | input | 64 | Scrambled payload of one block, bit 63 sent first |
| par_word | output | 12 | Parity of the most recently completed multiblock, held |
| par_done | output | 1 | One-cycle pulse when par_word takes a new value |

## Verification
The hardest case to reach is a start marker that lands in the middle of a multiblock after a partial result has built up. A second hard case is a start marker in the cycle right after a 32nd block, where the done pulse of one multiblock overlaps block 1 of the next. The stimulus builds both on purpose: it aborts a multiblock after ten blocks, and it runs multiblocks back to back with no idle cycle. It also scatters idle cycles carrying stray start markers and stray data between blocks. Orphan blocks presented while no multiblock is open check that they are dropped. A single set bit at either end of the first word checks the order in which bits enter.

// File: rtl/mbcrc_pkg.sv
package mbcrc_pkg;

  localparam int CRC_W  = 12;
  localparam int WORD_W = 64;
  localparam int BLOCKS = 32;
  // generator x^12 + x^9 + x^8 + x^3 + x^2 + x + 1, x^12 term implied
  localparam logic [CRC_W-1:0] POLY = 12'h30F;

  // one serial step: feedback from the top stage xored with the incoming bit
  function automatic logic [CRC_W-1:0] crc_bit(input logic [CRC_W-1:0] s,
                                               input logic b);
    logic fb;
    fb = s[CRC_W-1] ^ b;
    return {s[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
  endfunction

  // whole word, most-significant bit first
  function automatic logic [CRC_W-1:0] crc_word(input logic [CRC_W-1:0] s,
                                                input logic [WORD_W-1:0] d);
    logic [CRC_W-1:0] acc;
    acc = s;
    for (int i = WORD_W - 1; i >= 0; i--) acc = crc_bit(acc, d[i]);
    return acc;
  endfunction

  // which old state bits feed next-state bit r (linear map, unit vectors)
  function automatic logic [CRC_W-1:0] state_row(input int r);
    logic [CRC_W-1:0] row, e, col;
    row = '0;
    for (int j = 0; j < CRC_W; j++) begin
      e = '0;
      e[j] = 1'b1;
      col = crc_word(e, '0);
      row[j] = col[r];
    end
    return row;
  endfunction

  // which data bits feed next-state bit r
  function automatic logic [WORD_W-1:0] data_row(input int r);
    logic [WORD_W-1:0] row, e;
    logic [CRC_W-1:0] col;
    row = '0;
    for (int k = 0; k < WORD_W; k++) begin
      e = '0;
      e[k] = 1'b1;
      col = crc_word('0, e);
      row[k] = col[r];
    end
    return row;
  endfunction

endpackage

// File: rtl/mbcrc_seq.sv
module mbcrc_seq #(
  parameter int BLOCKS = mbcrc_pkg::BLOCKS,
  localparam int CNT_W = $clog2(BLOCKS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blk_valid,
  input  logic             blk_sop,
  output logic             blk_accept,
  output logic             blk_first,
  output logic             blk_last,
  output logic [CNT_W-1:0] blk_cnt
);

  logic open_mb;
  logic at_end;

  assign open_mb    = (blk_cnt != '0);
  assign blk_accept = blk_valid && (blk_sop || open_mb);
  assign blk_first  = blk_valid && blk_sop;
  assign at_end     = blk_sop ? (BLOCKS == 1) : (blk_cnt == CNT_W'(BLOCKS - 1));
  assign blk_last   = blk_accept && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_cnt <= '0;
    end else if (blk_last) begin
      blk_cnt <= '0;
    end else if (blk_first) begin
      blk_cnt <= CNT_W'(1);
    end else if (blk_accept) begin
      blk_cnt <= blk_cnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/mbcrc_engine.sv
module mbcrc_engine #(
  parameter int CRC_W  = mbcrc_pkg::CRC_W,
  parameter int WORD_W = mbcrc_pkg::WORD_W,
  parameter bit XOR_MATRIX = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blk_accept,
  input  logic              blk_first,
  input  logic              blk_last,
  input  logic [WORD_W-1:0] blk_data,
  output logic [CRC_W-1:0]  crc_state,
  output logic [CRC_W-1:0]  crc_next
);

  logic [CRC_W-1:0] seed;

  // a start marker begins again from zero, whatever was accumulated
  assign seed = blk_first ? '0 : crc_state;

  generate
    if (XOR_MATRIX) begin : g_matrix
      for (genvar r = 0; r < CRC_W; r++) begin : g_bit
        localparam logic [CRC_W-1:0]  SMASK = mbcrc_pkg::state_row(r);
        localparam logic [WORD_W-1:0] DMASK = mbcrc_pkg::data_row(r);
        assign crc_next[r] = (^(seed & SMASK)) ^ (^(blk_data & DMASK));
      end
    end else begin : g_serial
      assign crc_next = mbcrc_pkg::crc_word(seed, blk_data);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_state <= '0;
    end else if (blk_accept) begin
      crc_state <= blk_last ? '0 : crc_next;
    end
  end

endmodule

// File: rtl/mbcrc_hold.sv
module mbcrc_hold #(
  parameter int CRC_W = mbcrc_pkg::CRC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blk_last,
  input  logic [CRC_W-1:0] crc_next,
  output logic [CRC_W-1:0] par_word,
  output logic             par_done
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_word <= '0;
      par_done <= 1'b0;
    end else begin
      par_done <= blk_last;
      if (blk_last) par_word <= crc_next;
    end
  end

endmodule

// File: rtl/mbcrc_gen.sv
module mbcrc_gen #(
  parameter int CRC_W  = mbcrc_pkg::CRC_W,
  parameter int WORD_W = mbcrc_pkg::WORD_W,
  parameter int BLOCKS = mbcrc_pkg::BLOCKS,
  parameter bit XOR_MATRIX = 1'b1,
  localparam int CNT_W = $clog2(BLOCKS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blk_valid,
  input  logic              blk_sop,
  input  logic [WORD_W-1:0] blk_data,
  output logic [CRC_W-1:0]  par_word,
  output logic              par_done
);

  // internal events, named for the checker
  logic             blk_accept;
  logic             blk_first;
  logic             blk_last;
  logic [CNT_W-1:0] blk_cnt;
  logic [CRC_W-1:0] crc_state;
  logic [CRC_W-1:0] crc_next;

  mbcrc_seq #(.BLOCKS(BLOCKS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .blk_valid  (blk_valid),
    .blk_sop    (blk_sop),
    .blk_accept (blk_accept),
    .blk_first  (blk_first),
    .blk_last   (blk_last),
    .blk_cnt    (blk_cnt)
  );

  mbcrc_engine #(.CRC_W(CRC_W), .WORD_W(WORD_W), .XOR_MATRIX(XOR_MATRIX)) u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .blk_accept (blk_accept),
    .blk_first  (blk_first),
    .blk_last   (blk_last),
    .blk_data   (blk_data),
    .crc_state  (crc_state),
    .crc_next   (crc_next)
  );

  mbcrc_hold #(.CRC_W(CRC_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .blk_last (blk_last),
    .crc_next (crc_next),
    .par_word (par_word),
    .par_done (par_done)
  );

endmodule

// File: rtl/mbcrc_chk.sv
module mbcrc_chk #(
  parameter int CRC_W  = 12,
  parameter int BLOCKS = 32,
  parameter int CNT_W  = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             blk_valid,
  input logic             blk_sop,
  input logic             blk_accept,
  input logic             blk_last,
  input logic [CNT_W-1:0] blk_cnt,
  input logic [CRC_W-1:0] crc_state,
  input logic [CRC_W-1:0] par_word,
  input logic             par_done
);

  p_done_after_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
    blk_last |=> par_done);

  p_done_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    par_done |-> $past(blk_last));

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    par_done |=> !par_done);

  p_word_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !par_done |-> $stable(par_word));

  p_clear_after_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
    blk_last |=> (crc_state == '0));

  p_gap_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_valid |=> ($stable(blk_cnt) && $stable(crc_state)));

  p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_valid && blk_sop && BLOCKS > 1) |=> (blk_cnt == CNT_W'(1)));

  p_cnt_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    blk_cnt < CNT_W'(BLOCKS));

  p_orphan_dropped_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_valid && !blk_sop && blk_cnt == '0) |-> !blk_accept);

  p_sop_needs_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!blk_valid && blk_sop) |-> !blk_accept);

endmodule

bind mbcrc_gen mbcrc_chk #(.CRC_W(CRC_W), .BLOCKS(BLOCKS), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .blk_valid  (blk_valid),
  .blk_sop    (blk_sop),
  .blk_accept (blk_accept),
  .blk_last   (blk_last),
  .blk_cnt    (blk_cnt),
  .crc_state  (crc_state),
  .par_word   (par_word),
  .par_done   (par_done)
);

// File: tb/mbcrc_gen_test.sv
`timescale 1ns/1ps
module mbcrc_gen_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        blk_valid = 1'b0;
  logic        blk_sop = 1'b0;
  logic [63:0] blk_data = '0;
  logic [11:0] par_word;
  logic        par_done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  mbcrc_gen uut (
    .clk(clk), .rst_n(rst_n), .blk_valid(blk_valid), .blk_sop(blk_sop),
    .blk_data(blk_data), .par_word(par_word), .par_done(par_done)
  );

  // behavioural model: a bit queue and long division
  bit          mq[$];
  bit          in_mb = 0;
  logic [11:0] exp_word = '0;
  bit          exp_done = 0;
  string       cur_tag = "R1";
  logic [31:0] seed = 32'h1234_5678;

  function automatic logic [11:0] long_div();
    int rem = 0;
    int n = mq.size();
    for (int i = 0; i < n + 12; i++) begin
      rem = (rem << 1) | ((i < n) ? int'(mq[i]) : 0);
      if ((rem & 32'h1000) != 0) rem = rem ^ 32'h130F;
    end
    return rem[11:0];
  endfunction

  function automatic logic [63:0] rnd64();
    logic [31:0] a, b;
    seed = seed * 32'd1103515245 + 32'd12345; a = seed;
    seed = seed * 32'd1103515245 + 32'd12345; b = seed;
    return {a, b};
  endfunction

  task automatic compare();
    checks++;
    if (par_done !== exp_done) begin
      errors++;
      $display("FAIL %s: par_done=%b expected %b", cur_tag, par_done, exp_done);
    end
    checks++;
    if (par_word !== exp_word) begin
      errors++;
      $display("FAIL %s: par_word=%h expected %h", cur_tag, par_word, exp_word);
    end
  endtask

  task automatic step(input bit v, input bit s, input logic [63:0] d, input string tag);
    @(negedge clk);
    compare();
    cur_tag = tag;
    blk_valid = v; blk_sop = s; blk_data = d;
    exp_done = 0;
    if (v && s) begin
      mq.delete();
      in_mb = 1;
    end
    if (v && in_mb) begin
      for (int i = 63; i >= 0; i--) mq.push_back(d[i]);
      if (mq.size() == 2048) begin
        exp_word = long_div();
        exp_done = 1;
        mq.delete();
        in_mb = 0;
      end
    end
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, rnd64(), tag);
  endtask

  task automatic multiblock(input int gap_every, input string tag);
    for (int b = 0; b < 32; b++) begin
      step(1'b1, b == 0, rnd64(), tag);
      if (gap_every > 0 && (b % gap_every) == gap_every - 1)
        step(1'b0, rnd64() % 2 == 0, rnd64(), tag);  // R8: stray marker ignored
    end
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare();                       // R1 while in reset
    rst_n = 1'b1;
    idle(2, "R1");

    multiblock(0, "R2");
    multiblock(0, "R3");             // back to back, marker right after block 32
    idle(5, "R4");                   // held word with garbage on the inputs

    multiblock(3, "R5");             // gaps carrying random markers
    idle(2, "R8");

    for (int i = 0; i < 6; i++) step(1'b1, 1'b0, rnd64(), "R7");
    idle(1, "R7");

    for (int i = 0; i < 10; i++) step(1'b1, i == 0, rnd64(), "R6");
    multiblock(0, "R6");             // restart in the middle
    for (int i = 0; i < 31; i++) step(1'b1, i == 0, rnd64(), "R6");
    multiblock(7, "R6");             // restart at block 32

    for (int b = 0; b < 32; b++) step(1'b1, b == 0, (b == 0) ? 64'h8000_0000_0000_0000 : 64'h0, "R9");
    for (int b = 0; b < 32; b++) step(1'b1, b == 0, (b == 0) ? 64'h1 : 64'h0, "R9");
    for (int b = 0; b < 32; b++) step(1'b1, b == 0, (b == 31) ? 64'h1 : 64'h0, "R9");
    for (int b = 0; b < 32; b++) step(1'b1, b == 0, 64'hFFFF_FFFF_FFFF_FFFF, "R2");
    for (int b = 0; b < 32; b++) step(1'b1, b == 0, 64'h0, "R2");
    idle(3, "R4");

    @(negedge clk);
    compare();
    finished = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule